// File: doc/BRIEF.md
# Double-Buffered Serial Byte Transmitter

This block turns parallel bytes from a host into asynchronous serial frames on a single line. The host presents a byte on the data input. It then pulses an active-low write strobe. The byte is captured when the strobe returns high, and it lands in a holding register. From there it moves into a separate shift register as soon as the serial side is free. Because of the two registers, one byte can wait while the previous one is still on the line.

Each frame starts with one low start bit. Eight data bits follow, least-significant first, and one high stop bit ends the frame. Between frames the line rests high. All timing comes from a single clock running at sixteen times the bit rate. A 4-bit divider inside the block produces one enable per bit period.

The host sees a single status pin, which is high while the holding register is free. The host must write only while that pin is high, and that is the only back-pressure rule. Writes made while it is low are a protocol violation. The new byte overwrites the waiting one.

Top module: `serial_byte_tx`

## Requirements
- R1: While reset is asserted and after it is released, the serial line is high and the empty flag is high.
- R2: A byte is captured on the rising edge of the synchronized write strobe. The empty flag is low at the first falling clock edge after the second rising clock edge that follows the strobe's return high.
- R3: Holding the strobe low for any number of clocks captures nothing until it rises, and it then captures exactly one byte. The empty flag stays high while the strobe is held low, and exactly one frame results.
- R4: The empty flag returns high in the same clock in which the held byte moves into the shift register. That is the clock in which the start bit appears. While a byte waits behind a frame in flight, the flag stays low.
- R5: A frame is a low start bit, then data bits 0 through 7 in that order, then a high stop bit.
- R6: When a byte is waiting as a stop bit ends, the next start bit follows at once. Frame starts are then exactly 160 clocks apart, with no idle time between frames.
- R7: With nothing pending, the line stays high indefinitely after a frame.
- R8: Bytes leave in the order they were written. A byte written during a frame is sent after that frame.
- R9: Every bit, including start and stop, lasts exactly 16 clocks of the oversample clock. Bit timing restarts from zero whenever a frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_os_i | input | 1 | Oversample clock, sixteen times the bit rate |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_n_i | input | 1 | Active-low write strobe; byte captured on its rising edge |
| din_i | input | 8 | Byte to send; must be stable until two clocks after the strobe rises |
| empty_o | output | 1 | High when the holding register can accept a byte |
| txd_o | output | 1 | Serial output line, high when idle |

## Verification
On every cycle, the assertions check four things. The line is high whenever no frame is active, and a transfer into the shift register is always followed by a low start bit. The empty flag drops after a capture and rises after a transfer, and the stop bit is high at the moment a frame ends. Some behaviour shows only in the bench's scenarios: the bit order on the line, the 16-clock bit width, the ordering of bytes written during a frame, the gap-free spacing of consecutive frames, and the single frame produced by a long strobe pulse.

// File: rtl/txser_pkg.sv
package txser_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } tx_phase_t;

  localparam logic LINE_MARK  = 1'b1;
  localparam logic LINE_SPACE = 1'b0;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic rise
);
  logic stage1, stage2;

  // both stages rest at the inactive (high) level so reset cannot fake an edge
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= 1'b1;
      stage2 <= 1'b1;
    end else begin
      stage1 <= strobe_n;
      stage2 <= stage1;
    end
  end

  assign rise = stage1 & ~stage2;

  p_single_capture_r3: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/bit_tick_gen.sv
module bit_tick_gen #(
  parameter int RATIO = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  assign tick = run && (cnt == LAST);

  p_restart_aligns_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick);
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import txser_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] load_data,
  output logic                 txd,
  output logic                 busy,
  output logic                 frame_done
);
  localparam int CNT_W = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS);

  tx_phase_t             phase;
  logic [DATA_BITS-1:0]  shreg;
  logic [CNT_W-1:0]      bits_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      shreg    <= '0;
      bits_out <= '0;
      txd      <= LINE_MARK;
    end else if (load) begin
      phase    <= PH_START;
      shreg    <= load_data;
      bits_out <= '0;
      txd      <= LINE_SPACE;
    end else if (tick) begin
      unique case (phase)
        PH_START: begin
          phase    <= PH_DATA;
          txd      <= shreg[0];
          shreg    <= shreg >> 1;
          bits_out <= CNT_W'(1);
        end
        PH_DATA: begin
          if (bits_out == LAST_BIT) begin
            phase <= PH_STOP;
            txd   <= LINE_MARK;
          end else begin
            txd      <= shreg[0];
            shreg    <= shreg >> 1;
            bits_out <= bits_out + 1'b1;
          end
        end
        PH_STOP: begin
          phase    <= PH_IDLE;
          bits_out <= '0;
          txd      <= LINE_MARK;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy       = (phase != PH_IDLE);
  assign frame_done = tick && (phase == PH_STOP);

  p_stop_level_r5: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> txd);
  p_bitcount_bound_r5: assert property (@(posedge clk) disable iff (rst)
    bits_out <= LAST_BIT);
endmodule

// File: rtl/serial_byte_tx.sv
module serial_byte_tx #(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk_os_i,
  input  logic                 rst_i,
  input  logic                 wr_n_i,
  input  logic [DATA_BITS-1:0] din_i,
  output logic                 empty_o,
  output logic                 txd_o
);
  logic                 capture;
  logic                 tick;
  logic                 busy;
  logic                 frame_done;
  logic                 xfer;
  logic                 hold_full;
  logic [DATA_BITS-1:0] hold_reg;

  strobe_edge u_sync (
    .clk      (clk_os_i),
    .rst      (rst_i),
    .strobe_n (wr_n_i),
    .rise     (capture)
  );

  // move the waiting byte whenever the line is free or a stop bit just ended
  assign xfer = hold_full && (!busy || frame_done);

  always_ff @(posedge clk_os_i) begin
    if (rst_i) begin
      hold_reg  <= '0;
      hold_full <= 1'b0;
    end else if (capture) begin
      hold_reg  <= din_i;
      hold_full <= 1'b1;
    end else if (xfer) begin
      hold_full <= 1'b0;
    end
  end

  bit_tick_gen #(.RATIO(OVERSAMPLE)) u_div (
    .clk     (clk_os_i),
    .rst     (rst_i),
    .run     (busy),
    .restart (xfer),
    .tick    (tick)
  );

  tx_frame_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
    .clk        (clk_os_i),
    .rst        (rst_i),
    .tick       (tick),
    .load       (xfer),
    .load_data  (hold_reg),
    .txd        (txd_o),
    .busy       (busy),
    .frame_done (frame_done)
  );

  assign empty_o = ~hold_full;

  p_idle_line_high_r7: assert property (@(posedge clk_os_i) disable iff (rst_i)
    !busy |-> txd_o);
  p_start_follows_move_r5: assert property (@(posedge clk_os_i) disable iff (rst_i)
    xfer |=> (!txd_o && busy));
  p_empty_after_move_r4: assert property (@(posedge clk_os_i) disable iff (rst_i)
    (xfer && !capture) |=> empty_o);
  p_capture_fills_r2: assert property (@(posedge clk_os_i) disable iff (rst_i)
    capture |=> !empty_o);
endmodule

// File: tb/tb_serial_byte_tx.sv
module tb_serial_byte_tx;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] din = '0;
  logic       empty_o, txd_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  int starts[$];

  serial_byte_tx dut (
    .clk_os_i (clk),
    .rst_i    (rst),
    .wr_n_i   (wr_n),
    .din_i    (din),
    .empty_o  (empty_o),
    .txd_o    (txd_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // driver: waits for room, pushes the expected byte, pulses the strobe
  task automatic send(input logic [7:0] b, input int low_len);
    while (!empty_o) @(negedge clk);
    exp_q.push_back(b);
    din  = b;
    wr_n = 1'b0;
    repeat (low_len) @(negedge clk);
    chk(empty_o == 1'b1, "R3", "empty held while strobe low", empty_o, 1);
    wr_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(empty_o == 1'b0, "R2", "empty low after strobe rise", empty_o, 0);
  endtask

  // monitor: decodes frames from the line and compares against the queue
  initial begin
    logic [7:0] got;
    wait (rst == 1'b0);
    forever begin
      @(negedge clk);
      if (txd_o === 1'b0) begin
        starts.push_back(cyc);
        chk(empty_o == 1'b1, "R4", "empty high as start bit appears", empty_o, 1);
        repeat (BIT_CLKS/2 - 1) @(negedge clk);
        chk(txd_o == 1'b0, "R5", "start bit low at mid", txd_o, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT_CLKS) @(negedge clk);
          got[i] = txd_o;
        end
        repeat (BIT_CLKS) @(negedge clk);
        chk(txd_o == 1'b1, "R5", "stop bit high at mid", txd_o, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "frame with no byte written", got, -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R5/R9", "received byte", got, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    chk(txd_o == 1'b1, "R1", "line during reset", txd_o, 1);
    chk(empty_o == 1'b1, "R1", "empty during reset", empty_o, 1);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(txd_o == 1'b1, "R1", "line after reset", txd_o, 1);
    chk(empty_o == 1'b1, "R1", "empty after reset", empty_o, 1);

    // single frame from idle
    send(8'hA5, 2);
    wait (exp_q.size() == 0);
    repeat (BIT_CLKS) @(negedge clk);

    // burst: second byte waits in the holding register
    n0 = starts.size();
    send(8'h3C, 1);
    send(8'h81, 3);
    repeat (20) @(negedge clk);
    chk(empty_o == 1'b0, "R4", "empty low while byte waits", empty_o, 0);
    send(8'h00, 2);
    send(8'hFF, 2);
    wait (exp_q.size() == 0);
    repeat (BIT_CLKS) @(negedge clk);
    chk(starts.size() - n0 == 4, "R8", "frames in burst", starts.size() - n0, 4);
    for (int k = n0 + 1; k < starts.size(); k++)
      chk(starts[k] - starts[k-1] == 10 * BIT_CLKS, "R6", "frame spacing",
          starts[k] - starts[k-1], 10 * BIT_CLKS);

    // idle line holds high
    begin
      int lows = 0;
      n0 = starts.size();
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (!txd_o) lows++;
      end
      chk(lows == 0, "R7", "low samples while idle", lows, 0);
    end

    // long strobe gives one frame
    n0 = starts.size();
    send(8'h5A, 40);
    wait (exp_q.size() == 0);
    repeat (400) @(negedge clk);
    chk(starts.size() - n0 == 1, "R3", "frames from long strobe", starts.size() - n0, 1);
    chk(txd_o == 1'b1, "R7", "line high after last frame", txd_o, 1);

    send(8'h01, 1);
    wait (exp_q.size() == 0);
    repeat (BIT_CLKS) @(negedge clk);

    finished = 1;
    report();
  end
endmodule